// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Coalescing

This block holds the control and status state of one DMA channel. Software reaches it through a simple word-addressed register bus. The datapath that walks descriptors and moves data sits outside the block. It gets three things from here: a run indication through `halted`, a one-cycle `start_pulse`, and the current and tail descriptor pointers. In the other direction it reports a one-cycle pulse for each finished frame and a pulse when the descriptor chain reaches its tail.

Completion interrupts are coalesced in two ways. A reloadable counter raises the completion event only after a programmable number of frames. A delay timer, restarted by every completion, raises a delay event once a programmable number of `tick` pulses pass with no further completion. Both live values can be read in the status word. The interrupt line is the OR of the pending events, each gated by its enable bit.

A soft reset written through the control word returns the channel to its halted state. The reset bit stays visible until software next reads the control word.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After `rst_n` is released, the control word reads 0x0001_0002 and the status word reads 0x0001_0001, with `halted`=1, `idle`=0, `irq`=0 and `start_pulse`=0.
- R2: Register offsets (bytes, with bits 1:0 ignored) are 0x00 control, 0x04 status, 0x08 current descriptor and 0x10 tail descriptor, and any other offset reads 0. Control fields: bit 0 run, bit 1 always reads 1, bit 2 soft reset, bits 14:12 interrupt enables, bits 23:16 completion threshold, bits 31:24 delay value; all other bits read 0.
- R3: A control write with bit 0 set, when neither the written bit 2 nor a pending soft reset is set, clears `halted` and `idle` on the next edge. `start_pulse` is high for exactly the one cycle after that edge.
- R4: Each `frame_done` pulse decrements the completion count. If it reaches 0, status bit 12 is set and the count reloads from the threshold. Every control write reloads the count from the newly written threshold.
- R5: A `frame_done` pulse loads the delay timer with the delay value when that value is nonzero. Each `tick` decrements a nonzero timer, and a timer at 0 stays at 0. The tick that takes the timer from 1 to 0 sets status bit 13 and reloads the completion count.
- R6: The status word reads: bits 31:24 live timer, 23:16 live completion count, 14:12 pending events, bit 1 idle, bit 0 halted; all other bits read 0.
- R7: A status write clears each pending bit among 14:12 whose written bit is 1. No other status bit changes on a status write.
- R8: `irq` is high exactly when some status bit in 14:12 is set together with the control bit in the same position.
- R9: A control write with bit 2 set, or any control write while a soft reset is pending, sets the control word to 0x0001_0006 and the status word to 0x0001_0001 (timer 0, count 1, no pending event, halted) and ignores the run bit. The next control read returns bit 2 set and then clears it.
- R10: A `walk_done` pulse sets idle. A tail-pointer write clears idle. Writes to 0x08 and 0x10 read back and drive `cur_desc` and `tail_desc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| frame_done | input | 1 | One-cycle pulse per completed frame |
| walk_done | input | 1 | One-cycle pulse when the descriptor walk reaches the tail |
| tick | input | 1 | Delay timer time base |
| halted | output | 1 | Channel is halted |
| idle | output | 1 | Channel is idle |
| start_pulse | output | 1 | One-cycle pulse after a successful run command |
| irq | output | 1 | Interrupt line |
| cur_desc | output | PTR_W | Current descriptor pointer |
| tail_desc | output | PTR_W | Tail descriptor pointer |

## Verification
A wrong completion count or timer value appears in bits 23:16 or 31:24 of the very next status read. It also shows in the cycle the interrupt line should rise but does not, or rises early. A lost or stale enable or pending bit shows on `irq` one cycle after the event or the register write. A soft-reset bit that clears too early or too late shows on the first or the second control read after the reset write.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
    localparam int FLD_W = 8;
    localparam int EVT_W = 3;

    localparam logic [3:0] WIDX_CTRL = 4'd0;
    localparam logic [3:0] WIDX_STAT = 4'd1;
    localparam logic [3:0] WIDX_CUR  = 4'd2;
    localparam logic [3:0] WIDX_TAIL = 4'd4;

    typedef struct packed {
        logic [FLD_W-1:0] delay;
        logic [FLD_W-1:0] thresh;
        logic [EVT_W-1:0] irq_en;
        logic             srst;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/dma_coal_counter.sv
`timescale 1ns/1ps
module dma_coal_counter #(
    parameter int CNT_W     = 8,
    parameter int RST_VALUE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             dec,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q, dec_val;

    always_comb begin
        dec_val = cnt_q - CNT_W'(1);
        hit     = dec && !reload && (dec_val == '0);
        cnt_d   = cnt_q;
        if (reload || hit) begin
            cnt_d = thresh;
        end else if (dec) begin
            cnt_d = dec_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_W'(RST_VALUE);
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cnt_q == $past(thresh)); // R4
    AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !reload && !hit) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4
endmodule

// File: rtl/dma_delay_timer.sv
`timescale 1ns/1ps
module dma_delay_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] tmr_d, tmr_q;

    always_comb begin
        expire = !clear && !load && tick && (tmr_q == CNT_W'(1));
        tmr_d  = tmr_q;
        if (clear) begin
            tmr_d = '0;
        end else if (load) begin
            tmr_d = load_val;
        end else if (tick && tmr_q != '0) begin
            tmr_d = tmr_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign cnt = tmr_q;

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && !tick) |=> $stable(tmr_q)); // R5
    AST_TMR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && tick && tmr_q != '0) |=> tmr_q == $past(tmr_q) - CNT_W'(1)); // R5
    AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load && tmr_q == '0) |=> tmr_q == '0); // R5
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int PTR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frame_done,
    input  logic              walk_done,
    input  logic              tick,
    output logic              halted,
    output logic              idle,
    output logic              start_pulse,
    output logic              irq,
    output logic [PTR_W-1:0]  cur_desc,
    output logic [PTR_W-1:0]  tail_desc
);
    localparam int WIDX_W = ADDR_W - 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic             halted;
        logic             idle;
        logic [EVT_W-1:0] pend;
        logic [PTR_W-1:0] cur;
        logic [PTR_W-1:0] tail;
        logic             start;
    } state_t;

    state_t            st_d, st_q;
    logic [WIDX_W-1:0] widx;
    logic              wr_ctrl, wr_stat, wr_cur, wr_tail, rd_ctrl;
    logic              srst_now;
    logic [FLD_W-1:0]  thresh_nxt;
    logic [FLD_W-1:0]  coal_cnt, tmr_cnt;
    logic              coal_hit, tmr_expire;

    assign widx    = reg_addr[ADDR_W-1:2];
    assign wr_ctrl = reg_req && reg_we && widx == WIDX_W'(WIDX_CTRL);
    assign wr_stat = reg_req && reg_we && widx == WIDX_W'(WIDX_STAT);
    assign wr_cur  = reg_req && reg_we && widx == WIDX_W'(WIDX_CUR);
    assign wr_tail = reg_req && reg_we && widx == WIDX_W'(WIDX_TAIL);
    assign rd_ctrl = reg_req && !reg_we && widx == WIDX_W'(WIDX_CTRL);

    assign srst_now   = wr_ctrl && (reg_wdata[2] || st_q.ctrl.srst);
    assign thresh_nxt = srst_now ? FLD_W'(1)
                      : (wr_ctrl ? reg_wdata[23:16] : st_q.ctrl.thresh);

    dma_coal_counter #(.CNT_W(FLD_W), .RST_VALUE(1)) i_coal (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (wr_ctrl || tmr_expire),
        .dec    (frame_done),
        .thresh (thresh_nxt),
        .cnt    (coal_cnt),
        .hit    (coal_hit)
    );

    dma_delay_timer #(.CNT_W(FLD_W)) i_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (srst_now),
        .load     (frame_done && st_q.ctrl.delay != '0),
        .load_val (st_q.ctrl.delay),
        .tick     (tick),
        .cnt      (tmr_cnt),
        .expire   (tmr_expire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;

        if (walk_done) st_d.idle = 1'b1;
        if (wr_cur)    st_d.cur  = PTR_W'(reg_wdata);
        if (wr_tail) begin
            st_d.tail = PTR_W'(reg_wdata);
            st_d.idle = 1'b0;
        end
        if (rd_ctrl) st_d.ctrl.srst = 1'b0;

        if (wr_stat) st_d.pend = st_q.pend & ~reg_wdata[14:12];
        st_d.pend = st_d.pend | {1'b0, tmr_expire, coal_hit};

        if (srst_now) begin
            st_d.ctrl   = '{delay: '0, thresh: FLD_W'(1), irq_en: '0, srst: 1'b1, run: 1'b0};
            st_d.halted = 1'b1;
            st_d.idle   = 1'b0;
            st_d.pend   = '0;
        end else if (wr_ctrl) begin
            st_d.ctrl.delay  = reg_wdata[31:24];
            st_d.ctrl.thresh = reg_wdata[23:16];
            st_d.ctrl.irq_en = reg_wdata[14:12];
            st_d.ctrl.run    = reg_wdata[0];
            if (reg_wdata[0]) begin
                st_d.halted = 1'b0;
                st_d.idle   = 1'b0;
                st_d.start  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.ctrl   <= '{delay: '0, thresh: FLD_W'(1), irq_en: '0, srst: 1'b0, run: 1'b0};
            st_q.halted <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_req && !reg_we) begin
            case (widx)
                WIDX_W'(WIDX_CTRL): reg_rdata = {st_q.ctrl.delay, st_q.ctrl.thresh, 1'b0,
                                                  st_q.ctrl.irq_en, 9'b0, st_q.ctrl.srst,
                                                  1'b1, st_q.ctrl.run};
                WIDX_W'(WIDX_STAT): reg_rdata = {tmr_cnt, coal_cnt, 1'b0, st_q.pend,
                                                  10'b0, st_q.idle, st_q.halted};
                WIDX_W'(WIDX_CUR):  reg_rdata = 32'(st_q.cur);
                WIDX_W'(WIDX_TAIL): reg_rdata = 32'(st_q.tail);
                default:            reg_rdata = '0;
            endcase
        end
    end

    assign halted      = st_q.halted;
    assign idle        = st_q.idle;
    assign start_pulse = st_q.start;
    assign irq         = |(st_q.pend & st_q.ctrl.irq_en);
    assign cur_desc    = st_q.cur;
    assign tail_desc   = st_q.tail;

    AST_RUN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[0] && !reg_wdata[2] && !st_q.ctrl.srst)
        |=> (!halted && !idle && start_pulse)); // R3
    AST_SRST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[2]) |=> (halted && !irq && !start_pulse)); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[14:12] == 3'b111 && !frame_done && !tick) |=> !irq); // R7
    AST_TAIL_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tail |=> !idle); // R10
endmodule

// File: tb/test_dma_chan_ctrl.sv
`timescale 1ns/1ps
module test_dma_chan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        frame_done = 1'b0, walk_done = 1'b0, tick = 1'b0;
    logic        halted, idle, start_pulse, irq;
    logic [31:0] cur_desc, tail_desc;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    dma_chan_ctrl i_dma_chan_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_done(frame_done), .walk_done(walk_done), .tick(tick),
        .halted(halted), .idle(idle), .start_pulse(start_pulse), .irq(irq),
        .cur_desc(cur_desc), .tail_desc(tail_desc)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data and compare
    always @(negedge clk) begin
        if (reg_req && !reg_we) begin
            if (exp_q.size() == 0) begin
                chk(reg_rdata, 32'hxxxx_xxxx, "scoreboard underflow");
            end else begin
                chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(e); tag_q.push_back(tag);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
        @(posedge clk); #1;
        reg_req = 1'b0;
    endtask

    task automatic frame();
        @(posedge clk); #1; frame_done = 1'b1;
        @(posedge clk); #1; frame_done = 1'b0;
    endtask

    task automatic tk();
        @(posedge clk); #1; tick = 1'b1;
        @(posedge clk); #1; tick = 1'b0;
    endtask

    task automatic walk();
        @(posedge clk); #1; walk_done = 1'b1;
        @(posedge clk); #1; walk_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        chk(halted, 1, "R1 halted"); chk(idle, 0, "R1 idle");
        chk(irq, 0, "R1 irq"); chk(start_pulse, 0, "R1 start");
        rd(6'h00, 32'h0001_0002, "R1 ctrl reset");
        rd(6'h04, 32'h0001_0001, "R1 status reset");
        rd(6'h0C, 32'h0, "R2 unmapped offset");

        // R2 R3 run write, bit1 forced, start pulse
        wr(6'h00, 32'h0003_1001);
        chk(start_pulse, 1, "R3 start pulse");
        chk(halted, 0, "R3 halted cleared");
        @(posedge clk); #1;
        chk(start_pulse, 0, "R3 start one cycle");
        rd(6'h00, 32'h0003_1003, "R2 ctrl fields");
        rd(6'h04, 32'h0003_0000, "R4 reload on ctrl write");

        // R4 threshold of 3
        frame(); frame();
        rd(6'h04, 32'h0002_0000 - 32'h0001_0000, "R4 count after two frames");
        chk(irq, 0, "R8 no irq before threshold");
        frame();
        chk(irq, 1, "R8 irq at threshold");
        rd(6'h04, 32'h0003_1000, "R4 pending and reload");

        // R7 W1C
        wr(6'h04, 32'h0000_1000);
        chk(irq, 0, "R7 w1c clears irq");
        rd(6'h04, 32'h0003_0000, "R7 status after w1c");

        // R8 enable masking
        wr(6'h00, 32'h0002_0001);
        frame(); frame();
        chk(irq, 0, "R8 masked event");
        rd(6'h04, 32'h0002_1000, "R8 pending while masked");
        wr(6'h00, 32'h0002_1001);
        chk(irq, 1, "R8 enable exposes pending");
        wr(6'h04, 32'h0000_7000);

        // R5 delay timer
        wr(6'h00, 32'h0405_2001);
        frame();
        rd(6'h04, 32'h0404_0000, "R5 timer loaded R6 layout");
        tk(); tk(); tk();
        chk(irq, 0, "R5 no irq before expiry");
        tk();
        chk(irq, 1, "R5 expiry irq");
        rd(6'h04, 32'h0005_2000, "R5 expiry reloads count");
        tk();
        rd(6'h04, 32'h0005_2000, "R5 timer holds at zero");
        wr(6'h04, 32'h0000_2000);
        chk(irq, 0, "R7 clear delay event");
        frame(); tk(); tk(); frame();
        rd(6'h04, 32'h0403_0000, "R5 restart on completion");

        // R10 idle and pointers
        walk();
        chk(idle, 1, "R10 walk sets idle");
        rd(6'h04, 32'h0403_0002, "R6 idle bit");
        wr(6'h10, 32'h0000_0100);
        chk(idle, 0, "R10 tail clears idle");
        chk(tail_desc, 32'h0000_0100, "R10 tail output");
        walk();
        wr(6'h00, 32'h0405_2001);
        chk(idle, 0, "R3 run clears idle");
        wr(6'h08, 32'hABCD_0040);
        chk(cur_desc, 32'hABCD_0040, "R10 cur output");
        rd(6'h08, 32'hABCD_0040, "R10 cur readback");
        rd(6'h10, 32'h0000_0100, "R10 tail readback");

        // R9 soft reset
        frame(); tk(); tk(); tk(); tk();
        chk(irq, 1, "R5 event before soft reset");
        wr(6'h00, 32'h0000_0005);
        chk(halted, 1, "R9 halted"); chk(irq, 0, "R9 irq cleared");
        chk(start_pulse, 0, "R9 run ignored");
        rd(6'h04, 32'h0001_0001, "R9 status after soft reset");
        wr(6'h04, 32'h0000_0003);
        rd(6'h04, 32'h0001_0001, "R7 halted idle not writable");
        wr(6'h00, 32'h0000_0001);
        chk(halted, 1, "R9 run during pending reset");
        chk(start_pulse, 0, "R9 no start while pending");
        rd(6'h00, 32'h0001_0006, "R9 reset bit visible");
        rd(6'h00, 32'h0001_0002, "R9 reset bit self clears");
        wr(6'h00, 32'h0000_0001);
        chk(halted, 0, "R3 run after reset done");
        chk(start_pulse, 1, "R3 start after reset done");
        rd(6'h00, 32'h0000_0003, "R2 ctrl after run");

        repeat (2) @(posedge clk);
        chk(32'(exp_q.size()), 0, "scoreboard drained");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule